// File: doc/BRIEF.md
# Transmit Header CRC Generator

This block produces the 11-bit CRC that protects a transmit frame header. When a start strobe arrives, the block captures four header fields: a sync flag, a startup flag, an 11-bit frame identifier and a 7-bit payload length. It packs them into a 20-bit word and then moves that word through an 11-bit linear feedback register, one bit per clock cycle, starting with the most significant bit. When the last bit has been consumed, a one-cycle completion pulse is raised and the CRC appears on the result output. The result stays there until the next completion.

A direction flag is captured together with the fields. Transmit headers receive the computed CRC. Receive headers always report zero, because their CRC field is not generated locally. A start strobe that arrives while a computation is running has no effect. A start strobe in the same cycle as the completion pulse is accepted.

Top module: `hdr_crc_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o is 0, done_o is 0 and crc_o is 0.
- R2: The header word is packed with sync in bit 19, startup in bit 18, the frame identifier in bits 17:7 and the payload length in bits 6:0. It is consumed from bit 19 down to bit 0.
- R3: The register is loaded with 0x01A on every accepted start. On each bit, it shifts left by one. When the data bit differs from the register's bit 10 before the shift, the shifted value is XORed with 0x385.
- R4: A start is accepted on the rising edge where start_i=1 and busy_o=0. done_o is 1 in the cycle that follows the 20th rising edge after the accepting edge, and it is 0 in every cycle between.
- R5: done_o is high for exactly one cycle per accepted start.
- R6: crc_o changes only at the edge that raises done_o, and is held otherwise.
- R7: A start_i pulse while busy_o=1 is ignored. The running result and its timing are unchanged, and busy_o stays 1.
- R8: When tx_i=0 at the accepting edge, the reported crc_o is 0 regardless of the fields.
- R9: A start_i pulse in the cycle where done_o=1 is accepted. The new result follows 20 edges later, and the earlier result stays on crc_o until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; fields are sampled on the accepting edge |
| tx_i | input | 1 | 1 = transmit header (compute CRC), 0 = receive header (report 0) |
| sync_i | input | 1 | Sync frame flag (header bit 19) |
| startup_i | input | 1 | Startup frame flag (header bit 18) |
| fid_i | input | 11 | Frame identifier (header bits 17:7) |
| plen_i | input | 7 | Payload length (header bits 6:0) |
| busy_o | output | 1 | High while bits are being shifted |
| done_o | output | 1 | One-cycle completion pulse |
| crc_o | output | 11 | Last completed CRC result, held |

## Verification
The completion of one computation and the acceptance of the next can fall in the same cycle. The bench raises start_i exactly in the cycle where done_o is high. It then judges three things: the earlier CRC must stay on crc_o during that cycle and the following 19; done_o must fall the next cycle; and the second CRC must arrive on the 20th edge after the new acceptance. A second overlap puts a start inside a running computation. That start must change neither the finishing cycle nor the result.

// File: rtl/hcrc_pkg.sv
package hcrc_pkg;
  localparam int HC_FID_W = 11;
  localparam int HC_PL_W  = 7;
  localparam int HC_CRC_W = 11;
  localparam logic [HC_CRC_W-1:0] HC_POLY = 11'h385;
  localparam logic [HC_CRC_W-1:0] HC_SEED = 11'h01A;

  // two flag bits precede identifier and length
  function automatic int hdr_bits(input int fid_w, input int pl_w);
    return 2 + fid_w + pl_w;
  endfunction
endpackage

// File: rtl/hcrc_pack.sv
module hcrc_pack #(
  parameter int FID_W = hcrc_pkg::HC_FID_W,
  parameter int PL_W  = hcrc_pkg::HC_PL_W,
  localparam int HW   = hcrc_pkg::hdr_bits(FID_W, PL_W)
) (
  input  logic             sync_i,
  input  logic             startup_i,
  input  logic [FID_W-1:0] fid_i,
  input  logic [PL_W-1:0]  plen_i,
  output logic [HW-1:0]    word_o
);
  // R2: flags on top, identifier next, length at the bottom
  always_comb word_o = {sync_i, startup_i, fid_i, plen_i};
endmodule

// File: rtl/hcrc_ctrl.sv
module hcrc_ctrl #(
  parameter int NBITS = 20,
  localparam int CW   = $clog2(NBITS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic shift_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  logic [CW-1:0] left_q;
  logic          busy_q;
  logic          done_q;

  assign accept_o = start_i && !busy_q;
  assign shift_o  = busy_q;
  assign last_o   = busy_q && (left_q == CW'(1));
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        left_q <= CW'(NBITS);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        left_q <= left_q - CW'(1);
        if (last_o) busy_q <= 1'b0;
      end
    end
  end

  // R5: completion pulse lasts one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R4: at completion the engine is already idle
  a_r4_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  // R7: a strobe during a run neither reloads nor stalls the count
  a_r7_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && left_q != CW'(1)) |=> (busy_q && left_q == $past(left_q) - CW'(1)));
  // R4: done only follows the final counted bit
  a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy_q));
endmodule

// File: rtl/hcrc_lfsr.sv
module hcrc_lfsr #(
  parameter int NBITS = 20,
  parameter int CRC_W = hcrc_pkg::HC_CRC_W,
  parameter logic [CRC_W-1:0] POLY = hcrc_pkg::HC_POLY,
  parameter logic [CRC_W-1:0] SEED = hcrc_pkg::HC_SEED
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             last_i,
  input  logic             tx_i,
  input  logic [NBITS-1:0] word_i,
  output logic [CRC_W-1:0] crc_o
);
  // R3: one serial step; feedback when data bit and top bit disagree
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] r, input logic d);
    logic fb;
    fb = d ^ r[CRC_W-1];
    return {r[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  endfunction

  logic [CRC_W-1:0] acc_q;
  logic [NBITS-1:0] sr_q;
  logic             tx_q;
  logic [CRC_W-1:0] res_q;
  logic [CRC_W-1:0] acc_nxt;

  assign acc_nxt = crc_step(acc_q, sr_q[NBITS-1]);
  assign crc_o   = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      sr_q  <= '0;
      tx_q  <= 1'b0;
      res_q <= '0;
    end else begin
      if (load_i) begin
        acc_q <= SEED;
        sr_q  <= word_i;
        tx_q  <= tx_i;
      end else if (shift_i) begin
        acc_q <= acc_nxt;
        sr_q  <= {sr_q[NBITS-2:0], 1'b0};
      end
      // R8: receive headers report zero
      if (last_i) res_q <= tx_q ? acc_nxt : '0;
    end
  end

  // R6: result moves only on a completion edge
  a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(last_i) |-> $stable(res_q));
  // R8: receive header result is zero
  a_r8_rx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (last_i && !tx_q) |=> (res_q == '0));
  // R3: each accepted start seeds the register
  a_r3_seeded: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (acc_q == SEED));
endmodule

// File: rtl/hdr_crc_gen.sv
module hdr_crc_gen #(
  parameter int FID_W = hcrc_pkg::HC_FID_W,
  parameter int PL_W  = hcrc_pkg::HC_PL_W,
  parameter int CRC_W = hcrc_pkg::HC_CRC_W,
  parameter logic [CRC_W-1:0] POLY = hcrc_pkg::HC_POLY,
  parameter logic [CRC_W-1:0] SEED = hcrc_pkg::HC_SEED,
  localparam int NBITS = hcrc_pkg::hdr_bits(FID_W, PL_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             tx_i,
  input  logic             sync_i,
  input  logic             startup_i,
  input  logic [FID_W-1:0] fid_i,
  input  logic [PL_W-1:0]  plen_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CRC_W-1:0] crc_o
);
  logic [NBITS-1:0] word;
  logic             accept;
  logic             shift_en;
  logic             last_bit;

  hcrc_pack #(.FID_W(FID_W), .PL_W(PL_W)) u_pack (
    .sync_i(sync_i), .startup_i(startup_i), .fid_i(fid_i),
    .plen_i(plen_i), .word_o(word));

  hcrc_ctrl #(.NBITS(NBITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .accept_o(accept),
    .shift_o(shift_en), .last_o(last_bit), .busy_o(busy_o), .done_o(done_o));

  hcrc_lfsr #(.NBITS(NBITS), .CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .shift_i(shift_en),
    .last_i(last_bit), .tx_i(tx_i), .word_i(word), .crc_o(crc_o));

  // R9: a strobe in the completion cycle starts a new run
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> busy_o);
endmodule

// File: tb/hdr_crc_gen_bench.sv
module hdr_crc_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        tx_i = 1'b0;
  logic        sync_i = 1'b0;
  logic        startup_i = 1'b0;
  logic [10:0] fid_i = '0;
  logic [6:0]  plen_i = '0;
  logic        busy_o;
  logic        done_o;
  logic [10:0] crc_o;

  int runs = 0;
  int fails = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  hdr_crc_gen u_hdr_crc_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_i(tx_i),
    .sync_i(sync_i), .startup_i(startup_i), .fid_i(fid_i), .plen_i(plen_i),
    .busy_o(busy_o), .done_o(done_o), .crc_o(crc_o));

  // vector: {tx, sync, startup, fid[10:0], plen[6:0]}
  localparam logic [20:0] VEC [0:7] = '{
    {1'b1, 1'b0, 1'b0, 11'h000, 7'h00},
    {1'b1, 1'b1, 1'b1, 11'h7FF, 7'h7F},
    {1'b1, 1'b1, 1'b0, 11'h001, 7'h10},
    {1'b1, 1'b0, 1'b1, 11'h400, 7'h01},
    {1'b1, 1'b0, 1'b0, 11'h2A5, 7'h55},
    {1'b1, 1'b1, 1'b0, 11'h0C3, 7'h3C},
    {1'b0, 1'b1, 1'b1, 11'h5A5, 7'h2A},
    {1'b1, 1'b0, 1'b1, 11'h123, 7'h7E}
  };

  // R2/R3: model in integer arithmetic
  function automatic logic [10:0] model(input logic [20:0] v);
    int r;
    logic [19:0] w;
    r = 32'h01A;
    w = v[19:0];
    for (int b = 19; b >= 0; b--) begin
      int top;
      top = (r >> 10) & 1;
      r = (r << 1) & 32'h7FF;
      if (int'(w[b]) != top) r = r ^ 32'h385;
    end
    return v[20] ? r[10:0] : 11'h000;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [20:0] v);
    {tx_i, sync_i, startup_i, fid_i, plen_i} = v;
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic pulse(input logic [20:0] v);
    drive(v);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // from negedge after edge k: done must be low for 19 cycles, high after edge k+20
  task automatic await_result(input logic [10:0] exp, input logic [10:0] hold, input string req);
    bit quiet = 1;
    bit steady = 1;
    for (int i = 1; i < 20; i++) begin
      @(negedge clk);
      if (done_o) quiet = 0;
      if (crc_o !== hold) steady = 0;
    end
    check(quiet, "R4 early done", 32'(quiet), 1);
    check(steady, "R6 crc held during run", 32'(crc_o), 32'(hold));
    @(negedge clk);
    check(done_o === 1'b1, "R4 done timing", 32'(done_o), 1);
    check(crc_o === exp, req, 32'(crc_o), 32'(exp));
  endtask

  initial begin
    #1_000_000;
    if (!ended) begin
      runs++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    logic [10:0] prev;
    logic [10:0] e;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0 && crc_o === 11'h0, "R1 in reset",
          32'({busy_o, done_o, crc_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o === 1'b0 && done_o === 1'b0 && crc_o === 11'h0, "R1 after reset",
          32'({busy_o, done_o, crc_o}), 0);

    // table walk: R2, R3, R8, R5
    prev = 11'h0;
    foreach (VEC[k]) begin
      e = model(VEC[k]);
      pulse(VEC[k]);
      await_result(e, prev, VEC[k][20] ? "R3 crc value R2 packing" : "R8 rx zero");
      @(negedge clk);
      check(done_o === 1'b0, "R5 single pulse", 32'(done_o), 0);
      check(crc_o === e, "R6 crc held after done", 32'(crc_o), 32'(e));
      prev = e;
    end

    // R7: start while busy is ignored
    begin
      logic [20:0] a;
      logic [20:0] b;
      bit stay;
      a = {1'b1, 1'b1, 1'b0, 11'h3C1, 7'h19};
      b = {1'b1, 1'b0, 1'b1, 11'h0F0, 7'h66};
      e = model(a);
      pulse(a);                       // after E0
      repeat (5) @(negedge clk);      // after E5
      pulse(b);                       // strobe on E6, after E6
      check(busy_o === 1'b1, "R7 busy kept", 32'(busy_o), 1);
      stay = 1;
      for (int i = 7; i < 20; i++) begin
        @(negedge clk);
        if (done_o) stay = 0;
      end
      check(stay, "R7 no early done", 32'(stay), 1);
      @(negedge clk);                 // after E20
      check(done_o === 1'b1, "R7 original timing", 32'(done_o), 1);
      check(crc_o === e, "R7 original result", 32'(crc_o), 32'(e));
      prev = e;
    end

    // R9: restart in the completion cycle
    begin
      logic [20:0] c;
      logic [10:0] e2;
      c = {1'b1, 1'b1, 1'b1, 11'h6D2, 7'h0B};
      e2 = model(c);
      pulse(c);                       // strobe in done cycle
      check(done_o === 1'b0 && busy_o === 1'b1, "R9 restarted",
            32'({done_o, busy_o}), 1);
      await_result(e2, prev, "R9 second result");
    end

    @(negedge clk);
    ended = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule